// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer built for a slow clock domain. A 12-bit down-counter starts from a programmable period. It steps down once per prescaler tick, which comes every 128 clocks by default. Software keeps the watchdog from firing by writing a restart command that carries an 8-bit password. If the counter runs out first, the block does one of two things, chosen by a mode bit: it sends a one-cycle reset request to the system, or it raises an interrupt status flag. An enable mask gates that flag onto the interrupt output.

Register access uses a simple write strobe and a read strobe with a byte offset. Read data is registered and appears in the cycle after the read strobe. The mode register holds five controls:
- reset-or-interrupt selection
- the early-restart check
- a disable bit
- halt enables for a debug input
- halt enables for an idle input

After any restart, the control and mode registers refuse writes for a short lockout window. A write to the mode register is itself a restart.

Top module: `kwd_timer`

## Requirements
- R1: A write to offset 0x00 restarts the counter only when bits 31:24 equal 0xA5 and bit 0 is 1. A restart reloads the counter from the period register and clears the prescaler. Other bits are ignored. Every other write to 0x00, and a write to any other offset except 0x04, restarts nothing.
- R2: A write to offset 0x04 that is accepted stores the mode fields and also restarts the counter. The mode fields are: bit 4 reset-select, bit 5 early-restart check, bit 12 disable, bit 28 debug-halt enable, bit 29 idle-halt enable. The register reads back at 0x04 with the same bit positions.
- R3: The period register sits at 0x0C, bits 11:0. The counter reads back at 0x08 and ignores writes. While running, the counter steps down once every DIV clocks, counted from the restart. On the tick where the counter is already 0, it expires and reloads from the period. Expiry therefore comes (P+1)*DIV clocks after a restart with period P.
- R4: With reset-select set, an expiry drives `wd_rst_req` high for exactly one clock, in the cycle after the expiring edge. The status flag is not touched.
- R5: With reset-select clear, an expiry sets status bit 0. `wd_irq` is high exactly when the status flag and the mask bit are both set.
- R6: Writing 1 to bit 0 at offset 0x14 sets the mask. Writing 1 to bit 0 at offset 0x18 clears it.
- R7: Reading offset 0x1C returns the status flag in bit 0 and clears the flag. If an expiry lands in the same cycle, the flag stays set.
- R8: For LOCK_CYC clocks (default 3) after a restart, writes to 0x00 and 0x04 are ignored. The first write after the window is accepted. Writes to the period and mask registers are never locked.
- R9: While the disable bit is set, the counter holds its value and no expiry occurs.
- R10: The counter holds in two cases: `dbg_halt` is high while debug-halt is enabled, or `idle_halt` is high while idle-halt is enabled. A halt input whose enable is clear has no effect.
- R11: When the early-restart check is on and a key restart arrives while the counter is above ERR_LIMIT (default 0xFF0), the restart acts as an expiry. A value equal to ERR_LIMIT is not an error.
- R12: After reset:
  - mode reads 0x00000010
  - period and counter read 0xFFF
  - mask, status, `wd_irq` and `wd_rst_req` are 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after `rd_en` |
| dbg_halt | input | 1 | Debug state indication |
| idle_halt | input | 1 | Idle state indication |
| wd_rst_req | output | 1 | One-cycle reset request on expiry |
| wd_irq | output | 1 | Masked period interrupt |

## Verification
Two situations are hard to reach from the ports:
- **Lockout boundary.** The stimulus drives back-to-back writes on consecutive edges: a restart, three mode writes inside the window, then a mode write on the first free edge. A single readback of the mode register then shows whether the window was one cycle too long or too short.
- **Early-restart error.** The counter has to sit above the limit when the key arrives. The bench loads a near-full period through a mode write, which restarts the counter without being checked. It then issues the key write as soon as the lockout ends. A second pass uses a period exactly at the limit, and a third turns the check off, to pin down the comparison.

Acceptance of each restart candidate is judged by timing against a known expiry. This is driven from a table of vectors.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] A_MODE  = 5'h04;
  localparam logic [ADDR_W-1:0] A_COUNT = 5'h08;
  localparam logic [ADDR_W-1:0] A_PER   = 5'h0C;
  localparam logic [ADDR_W-1:0] A_MSET  = 5'h14;
  localparam logic [ADDR_W-1:0] A_MCLR  = 5'h18;
  localparam logic [ADDR_W-1:0] A_STAT  = 5'h1C;

  localparam logic [7:0] RESTART_KEY = 8'hA5;

  localparam int B_GO     = 0;
  localparam int B_RSTSEL = 4;
  localparam int B_MINCHK = 5;
  localparam int B_OFF    = 12;
  localparam int B_DBG    = 28;
  localparam int B_IDLE   = 29;
  localparam int B_EVT    = 0;

  typedef struct packed {
    logic idle_hlt;
    logic dbg_hlt;
    logic off;
    logic min_chk;
    logic rst_sel;
  } mode_t;

  localparam mode_t MODE_RESET = '{idle_hlt: 1'b0, dbg_hlt: 1'b0, off: 1'b0,
                                   min_chk: 1'b0, rst_sel: 1'b1};

  function automatic mode_t mode_unpack(input logic [31:0] w);
    mode_t m;
    m.idle_hlt = w[B_IDLE];
    m.dbg_hlt  = w[B_DBG];
    m.off      = w[B_OFF];
    m.min_chk  = w[B_MINCHK];
    m.rst_sel  = w[B_RSTSEL];
    return m;
  endfunction

  function automatic logic [31:0] mode_pack(input mode_t m);
    logic [31:0] w;
    w = '0;
    w[B_IDLE]   = m.idle_hlt;
    w[B_DBG]    = m.dbg_hlt;
    w[B_OFF]    = m.off;
    w[B_MINCHK] = m.min_chk;
    w[B_RSTSEL] = m.rst_sel;
    return w;
  endfunction

endpackage

// File: rtl/kwd_prescale.sv
module kwd_prescale #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_q <= '0;
    end else if (run) begin
      if (pre_q == LAST) pre_q <= '0;
      else               pre_q <= pre_q + 1'b1;
    end
  end

  assign tick = run && !clear && (pre_q == LAST);

  // a restart always leaves a full tick interval before the next step
  AST_NO_TICK_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clear |=> !tick); // R3

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int CNT_W     = 12,
  parameter int ERR_LIMIT = 4080
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             chk_en,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ERR_LIMIT);

  logic at_zero;
  logic early;

  assign at_zero = (cnt == '0);
  assign early   = chk_en && (cnt > LIMIT);
  assign expire  = (tick && at_zero && !restart) || early;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '1;
    end else if (restart) begin
      cnt <= period;
    end else if (tick) begin
      if (at_zero) cnt <= period;
      else         cnt <= cnt - 1'b1;
    end
  end

  AST_RELOAD_ON_RESTART: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == $past(period))); // R1

  AST_ZERO_TICK_EXPIRES: assert property (@(posedge clk) disable iff (rst)
    (tick && at_zero) |-> expire); // R3

endmodule

// File: rtl/kwd_event.sv
module kwd_event (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic rst_sel,
  input  logic mask_set,
  input  logic mask_clr,
  input  logic status_rd,
  output logic status_q,
  output logic mask_q,
  output logic irq,
  output logic rst_req
);
  logic nst;
  logic nmask;

  always_comb begin
    if (expire && !rst_sel) nst = 1'b1;
    else if (status_rd)     nst = 1'b0;
    else                    nst = status_q;

    if (mask_set)      nmask = 1'b1;
    else if (mask_clr) nmask = 1'b0;
    else               nmask = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 1'b0;
      mask_q   <= 1'b0;
      irq      <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      status_q <= nst;
      mask_q   <= nmask;
      irq      <= nst && nmask;
      rst_req  <= expire && rst_sel;
    end
  end

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req); // R4

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    irq |-> (mask_q && status_q)); // R5

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !expire) |=> !status_q); // R7

endmodule

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int LOCK_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              status,
  output mode_t             mode,
  output logic [CNT_W-1:0]  period,
  output logic              restart,
  output logic              key_restart,
  output logic              mask_set,
  output logic              mask_clr,
  output logic              status_rd,
  output logic [31:0]       rdata
);
  localparam int LK_W = $clog2(LOCK_CYC + 1);
  localparam logic [LK_W-1:0] LK_START = LK_W'(LOCK_CYC);

  logic [LK_W-1:0] lock_q;
  logic            locked;
  logic            wr_ctrl, wr_mode, wr_per;
  logic            mode_ok;
  logic [31:0]     rd_mux;

  assign locked      = (lock_q != '0);
  assign wr_ctrl     = wr_en && (addr == A_CTRL);
  assign wr_mode     = wr_en && (addr == A_MODE);
  assign wr_per      = wr_en && (addr == A_PER);
  assign key_restart = wr_ctrl && !locked && wdata[B_GO] && (wdata[31:24] == RESTART_KEY);
  assign mode_ok     = wr_mode && !locked;
  assign restart     = key_restart || mode_ok;
  assign mask_set    = wr_en && (addr == A_MSET) && wdata[B_EVT];
  assign mask_clr    = wr_en && (addr == A_MCLR) && wdata[B_EVT];
  assign status_rd   = rd_en && (addr == A_STAT);

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_MODE:  rd_mux = mode_pack(mode);
      A_COUNT: rd_mux[CNT_W-1:0] = cnt_val;
      A_PER:   rd_mux[CNT_W-1:0] = period;
      A_STAT:  rd_mux[B_EVT] = status;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= MODE_RESET;
      period <= '1;
      lock_q <= '0;
      rdata  <= '0;
    end else begin
      if (mode_ok) mode   <= mode_unpack(wdata);
      if (wr_per)  period <= wdata[CNT_W-1:0];
      if (restart)     lock_q <= LK_START;
      else if (locked) lock_q <= lock_q - 1'b1;
      if (rd_en) rdata <= rd_mux;
    end
  end

  AST_LOCK_HOLDS_MODE: assert property (@(posedge clk) disable iff (rst)
    (wr_mode && locked) |=> (mode == $past(mode))); // R8

  AST_LOCK_AFTER_RESTART: assert property (@(posedge clk) disable iff (rst)
    restart |=> !restart); // R8

endmodule

// File: rtl/kwd_timer.sv
module kwd_timer
  import kwd_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int DIV       = 128,
  parameter int LOCK_CYC  = 3,
  parameter int ERR_LIMIT = 4080
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              dbg_halt,
  input  logic              idle_halt,
  output logic              wd_rst_req,
  output logic              wd_irq
);
  mode_t            mode;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] cnt;
  logic             restart, key_restart;
  logic             mask_set, mask_clr, status_rd;
  logic             status_q, mask_q;
  logic             run, tick, expire;

  assign run = !mode.off && !(mode.dbg_hlt && dbg_halt) && !(mode.idle_hlt && idle_halt);

  kwd_regs #(.CNT_W(CNT_W), .LOCK_CYC(LOCK_CYC)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .cnt_val(cnt), .status(status_q), .mode(mode), .period(period),
    .restart(restart), .key_restart(key_restart), .mask_set(mask_set),
    .mask_clr(mask_clr), .status_rd(status_rd), .rdata(rdata)
  );

  kwd_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .clear(restart), .run(run), .tick(tick)
  );

  kwd_counter #(.CNT_W(CNT_W), .ERR_LIMIT(ERR_LIMIT)) u_cnt (
    .clk(clk), .rst(rst), .restart(restart), .chk_en(key_restart && mode.min_chk),
    .tick(tick), .period(period), .cnt(cnt), .expire(expire)
  );

  kwd_event u_evt (
    .clk(clk), .rst(rst), .expire(expire), .rst_sel(mode.rst_sel),
    .mask_set(mask_set), .mask_clr(mask_clr), .status_rd(status_rd),
    .status_q(status_q), .mask_q(mask_q), .irq(wd_irq), .rst_req(wd_rst_req)
  );

  AST_NO_COUNT_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> (cnt == $past(cnt))); // R9

  AST_NO_EXPIRE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode.off && !restart) |-> !expire); // R9

endmodule

// File: tb/sim_kwd_timer.sv
`timescale 1ns/1ps
module sim_kwd_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        dbg_halt = 1'b0, idle_halt = 1'b0;
  logic        wd_rst_req, wd_irq;

  int checks = 0, fails = 0, pulses = 0, base = 0;
  bit done = 0;
  logic [31:0] q;

  always #2.5 clk = ~clk;

  kwd_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .dbg_halt(dbg_halt), .idle_halt(idle_halt),
    .wd_rst_req(wd_rst_req), .wd_irq(wd_irq)
  );

  always @(negedge clk) if (wd_rst_req) pulses++;

  typedef struct packed { logic [4:0] a; logic [31:0] d; logic acc; } vec_t;
  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{5'h00, 32'hA5000001, 1'b1},  // R1 good key
    '{5'h00, 32'hA5000000, 1'b0},  // R1 go bit clear
    '{5'h00, 32'hA4000001, 1'b0},  // R1 wrong key
    '{5'h00, 32'h00000001, 1'b0},  // R1 no key
    '{5'h00, 32'hA5FFFFFF, 1'b1},  // R1 other bits ignored
    '{5'h04, 32'h00000010, 1'b1},  // R2 mode write restarts
    '{5'h0C, 32'h00000001, 1'b0},  // R3 period write is no restart
    '{5'h08, 32'hA5000001, 1'b0}   // R3 counter offset ignores writes
  };

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] r);
    addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    r = rdata; rd_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    rd(5'h04, q); chk("R12 mode", q, 32'h10);
    rd(5'h0C, q); chk("R12 period", q, 32'hFFF);
    rd(5'h08, q); chk("R12 counter", q, 32'hFFF);
    rd(5'h1C, q); chk("R12 status", q, 32'h0);
    chk("R12 irq", {31'b0, wd_irq}, 32'h0);
    chk("R12 rst_req", {31'b0, wd_rst_req}, 32'h0);

    wr(5'h0C, 32'h1);
    rd(5'h0C, q); chk("R3 period readback", q, 32'h1);

    // table walk: accepted restart postpones the expiry of the earlier good restart
    for (int i = 0; i < NV; i++) begin
      wr(5'h00, 32'hA5000001);
      base = pulses;
      wait_n(150);
      wr(VEC[i].a, VEC[i].d);
      wait_n(150);
      chk($sformatf("R1/R2/R3 vector %0d", i), pulses - base, VEC[i].acc ? 0 : 1);
    end

    // R3 / R4 exact expiry timing, period 2
    wr(5'h0C, 32'h2);
    wr(5'h00, 32'hA5000001);
    wait_n(383); chk("R3 before expiry", {31'b0, wd_rst_req}, 32'h0);
    wait_n(1);   chk("R4 pulse high", {31'b0, wd_rst_req}, 32'h1);
    wait_n(1);   chk("R4 pulse one cycle", {31'b0, wd_rst_req}, 32'h0);
    rd(5'h08, q); chk("R3 reload on expiry", q, 32'h2);
    rd(5'h1C, q); chk("R4 no status in reset mode", q, 32'h0);
    wr(5'h00, 32'hA5000001);
    wait_n(130);
    rd(5'h08, q); chk("R3 one step", q, 32'h1);

    // R8 lockout boundary
    wr(5'h00, 32'hA5000001);
    wr(5'h04, 32'h1010);
    wr(5'h04, 32'h1010);
    wr(5'h04, 32'h1010);
    wr(5'h04, 32'h20000010);
    rd(5'h04, q); chk("R8 lock window", q, 32'h20000010);
    wait_n(5);
    wr(5'h04, 32'h10);
    wr(5'h0C, 32'h5);
    rd(5'h0C, q); chk("R8 period not locked", q, 32'h5);

    // R9 disable
    wait_n(5);
    wr(5'h0C, 32'h1);
    wr(5'h04, 32'h1010);
    base = pulses;
    wait_n(600);
    chk("R9 no expiry", pulses - base, 0);
    rd(5'h08, q); chk("R9 counter held", q, 32'h1);

    // R10 halts
    dbg_halt = 1'b1;
    wr(5'h04, 32'h10000010);
    base = pulses;
    wait_n(600);
    chk("R10 debug halt", pulses - base, 0);
    rd(5'h08, q); chk("R10 debug counter held", q, 32'h1);
    dbg_halt = 1'b0;
    idle_halt = 1'b1;
    wr(5'h04, 32'h10);
    base = pulses;
    wait_n(600);
    chk("R10 idle input without enable", pulses - base, 2);
    wr(5'h04, 32'h20000010);
    base = pulses;
    wait_n(600);
    chk("R10 idle halt", pulses - base, 0);
    idle_halt = 1'b0;

    // R5 / R6 / R7 interrupt mode
    wr(5'h14, 32'h1);
    wr(5'h04, 32'h0);
    base = pulses;
    wait_n(300);
    chk("R5 irq raised", {31'b0, wd_irq}, 32'h1);
    chk("R5 no reset request", pulses - base, 0);
    wr(5'h18, 32'h1);
    chk("R6 mask clear", {31'b0, wd_irq}, 32'h0);
    wr(5'h14, 32'h1);
    chk("R6 mask set", {31'b0, wd_irq}, 32'h1);
    rd(5'h1C, q); chk("R7 status read", q, 32'h1);
    chk("R7 irq after clear", {31'b0, wd_irq}, 32'h0);
    rd(5'h1C, q); chk("R7 status cleared", q, 32'h0);
    wr(5'h18, 32'h1);

    // R11 early restart check
    wait_n(5);
    wr(5'h0C, 32'hFF8);
    wr(5'h04, 32'h30);
    wait_n(5);
    base = pulses;
    wr(5'h00, 32'hA5000001);
    wait_n(2);
    chk("R11 early restart error", pulses - base, 1);
    wait_n(5);
    wr(5'h0C, 32'hFF0);
    wr(5'h04, 32'h30);
    wait_n(5);
    base = pulses;
    wr(5'h00, 32'hA5000001);
    wait_n(2);
    chk("R11 at limit no error", pulses - base, 0);
    wait_n(5);
    wr(5'h0C, 32'hFF8);
    wr(5'h04, 32'h10);
    wait_n(5);
    base = pulses;
    wr(5'h00, 32'hA5000001);
    wait_n(2);
    chk("R11 check off", pulses - base, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule